// File: doc/BRIEF.md
# NAND Flash Bus Cycle Timer

This block turns single-byte requests into the strobe waveforms of an 8-bit asynchronous NAND flash bus. A request names one of four cycle kinds (command latch, address latch, data write, data read) and carries a byte. The block then walks through three timed phases, each counted in controller clock cycles: a setup phase where the latch-enable lines settle, an active phase where the write or read strobe is low, and a hold phase after the strobe returns high. Only one cycle runs at a time, and `busy` holds off new requests until the hold phase is over.

The three phase lengths live in a small timing bank. Each field is loaded as the wanted cycle count minus one, and the bank resets to the longest lengths. The setup field is two bits wide in the basic build (1 to 4 cycles) and three bits in the extended build (1 to 8 cycles). The active and hold fields always span 1 to 8 cycles. The block also registers a chip-enable line from a select input and brings the flash ready/busy pin through a two-flop synchronizer.

States of the sequencer: `ST_IDLE` (no cycle), `ST_SETUP`, `ST_ACTIVE`, `ST_HOLD`. Transitions: `ST_IDLE -> ST_SETUP` when a request is accepted; `ST_SETUP -> ST_ACTIVE`, `ST_ACTIVE -> ST_HOLD` and `ST_HOLD -> ST_IDLE` each when the phase counter reaches zero; otherwise each phase stays put and counts down.

Top module: `nand_strobe_sequencer`

## Requirements
- R1: While reset is held and right after it is released, `nce_n`, `we_n` and `re_n` are 1, `cle`, `ale`, `busy`, `dq_oe`, `rd_valid` and `ready` are 0, and `rd_data` is 0.
- R2: An accepted request lasts exactly (setup+1) + (width+1) + (hold+1) cycles, in the order setup, active, hold. The setup phase starts in the cycle after the accepting edge. Each length is its field value plus one.
- R3: After reset the setup phase lasts 4 cycles (8 when `EXT_SETUP`=1), and the active and hold phases last 8 cycles each.
- R4: Kind 2'b00 (command) holds `cle` high across all three phases. It pulls `we_n` low only in the active phase, and drives `req_byte` on `dq_out` with `dq_oe`=1 for the whole cycle.
- R5: Kind 2'b01 (address) behaves like R4, with `ale` high in place of `cle`.
- R6: Kind 2'b10 (data write) keeps both `cle` and `ale` low. It pulls `we_n` low only in the active phase and drives the byte with `dq_oe`=1 for the whole cycle.
- R7: Kind 2'b11 (data read) keeps `dq_oe` at 0 and pulls `re_n` low only in the active phase. `dq_in` is captured into `rd_data` on the edge where `re_n` returns high, and `rd_valid` is high for the one cycle after that edge. `rd_data` keeps its value until the next read.
- R8: `busy` is 1 from the accepting edge to the end of the last hold cycle. A request presented while `busy`=1 has no effect.
- R9: A `tim_load` pulse while idle sets the lengths for later requests. A `tim_load` while `busy`=1 is ignored.
- R10: `ready` follows `rnb_in` (1 = flash ready) two clock edges later.
- R11: `nce_n` equals the inverse of `sel_chip` one edge later, and resets high.
- R12: `we_n` and `re_n` are never low together, and `cle` and `ale` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tim_load | input | 1 | Load the three timing fields (taken only while idle) |
| tim_setup | input | SETUP_W | Setup phase cycles minus one |
| tim_width | input | PHASE_W | Active phase cycles minus one |
| tim_hold | input | PHASE_W | Hold phase cycles minus one |
| req_valid | input | 1 | Request strobe, accepted when `busy` is 0 |
| req_kind | input | 2 | 00 command, 01 address, 10 write, 11 read |
| req_byte | input | DQ_W | Byte for command, address or write |
| busy | output | 1 | A bus cycle is in progress |
| sel_chip | input | 1 | 1 selects the flash chip |
| rnb_in | input | 1 | Raw ready/busy pin from the flash |
| ready | output | 1 | Synchronized ready/busy, 1 = ready |
| nce_n | output | 1 | Chip enable, active low |
| cle | output | 1 | Command latch enable |
| ale | output | 1 | Address latch enable |
| we_n | output | 1 | Write strobe, active low |
| re_n | output | 1 | Read strobe, active low |
| dq_out | output | DQ_W | Data bus out |
| dq_oe | output | 1 | Data bus output enable |
| dq_in | input | DQ_W | Data bus in |
| rd_data | output | DQ_W | Byte captured by the last read |
| rd_valid | output | 1 | One-cycle pulse when `rd_data` updates |

## Verification
The assertions assume that every input changes only between clock edges, in step with `clk`. The one exception is `rnb_in`, which may change at any time but is only read through the synchronizer. They also assume that `dq_in` is steady at the edge that ends a read's active phase. The stimulus drives all inputs on the falling edge, keeps `dq_in` fixed for the whole of each read, and never issues a request and a timing load on the same edge. Requests and timing loads sent while a cycle is running are included on purpose, to show that both are ignored.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

    typedef enum logic [1:0] {
        K_CMD   = 2'b00,
        K_ADDR  = 2'b01,
        K_WRITE = 2'b10,
        K_READ  = 2'b11
    } bus_kind_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'b00,
        ST_SETUP  = 2'b01,
        ST_ACTIVE = 2'b10,
        ST_HOLD   = 2'b11
    } seq_state_t;

endpackage

// File: rtl/nand_timing_bank.sv
module nand_timing_bank #(
    parameter int SETUP_W = 2,
    parameter int PHASE_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               idle,
    input  logic [SETUP_W-1:0] setup_in,
    input  logic [PHASE_W-1:0] width_in,
    input  logic [PHASE_W-1:0] hold_in,
    output logic [PHASE_W-1:0] setup_len,
    output logic [PHASE_W-1:0] width_len,
    output logic [PHASE_W-1:0] hold_len
);
    logic [SETUP_W-1:0] setup_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            setup_q   <= '1;
            width_len <= '1;
            hold_len  <= '1;
        end else if (load && idle) begin
            setup_q   <= setup_in;
            width_len <= width_in;
            hold_len  <= hold_in;
        end
    end

    generate
        if (SETUP_W < PHASE_W) begin : g_narrow
            assign setup_len = {{(PHASE_W-SETUP_W){1'b0}}, setup_q};
        end else begin : g_full
            assign setup_len = setup_q[PHASE_W-1:0];
        end
    endgenerate

    // R9: lengths never change while a cycle runs
    a_r9_frozen_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !idle |=> ($stable(width_len) && $stable(hold_len) && $stable(setup_len)));

endmodule

// File: rtl/nand_rnb_sync.sv
module nand_rnb_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q   <= 1'b0;
            sync_out <= 1'b0;
        end else begin
            meta_q   <= async_in;
            sync_out <= meta_q;
        end
    end

    // R10: output transitions reflect the pin two edges earlier
    a_r10_rise_lag: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_out) |-> $past(async_in, 2));
    a_r10_fall_lag: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sync_out) |-> !$past(async_in, 2));

endmodule

// File: rtl/nand_strobe_fsm.sv
module nand_strobe_fsm
    import nand_seq_pkg::*;
#(
    parameter int PHASE_W = 3,
    parameter int DQ_W    = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [1:0]         req_kind,
    input  logic [DQ_W-1:0]    req_byte,
    input  logic [PHASE_W-1:0] setup_len,
    input  logic [PHASE_W-1:0] width_len,
    input  logic [PHASE_W-1:0] hold_len,
    input  logic [DQ_W-1:0]    dq_in,
    output logic               busy,
    output logic               cle,
    output logic               ale,
    output logic               we_n,
    output logic               re_n,
    output logic [DQ_W-1:0]    dq_out,
    output logic               dq_oe,
    output logic [DQ_W-1:0]    rd_data,
    output logic               rd_valid
);
    seq_state_t         state_q, state_d;
    logic [PHASE_W-1:0] cnt_q, cnt_d;
    bus_kind_t          kind_q;
    logic [DQ_W-1:0]    byte_q;
    logic               accept;
    logic               read_end;

    assign accept   = req_valid && (state_q == ST_IDLE);
    assign read_end = (state_q == ST_ACTIVE) && (cnt_q == '0) && (kind_q == K_READ);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            cnt_q    <= '0;
            kind_q   <= K_CMD;
            byte_q   <= '0;
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            state_q  <= state_d;
            cnt_q    <= cnt_d;
            rd_valid <= read_end;
            if (accept) begin
                kind_q <= bus_kind_t'(req_kind);
                byte_q <= req_byte;
            end
            if (read_end) begin
                rd_data <= dq_in;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    state_d = ST_SETUP;
                    cnt_d   = setup_len;
                end
            end
            ST_SETUP: begin
                if (cnt_q == '0) begin
                    state_d = ST_ACTIVE;
                    cnt_d   = width_len;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            ST_ACTIVE: begin
                if (cnt_q == '0) begin
                    state_d = ST_HOLD;
                    cnt_d   = hold_len;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            ST_HOLD: begin
                if (cnt_q == '0) begin
                    state_d = ST_IDLE;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        busy   = (state_q != ST_IDLE);
        cle    = busy && (kind_q == K_CMD);
        ale    = busy && (kind_q == K_ADDR);
        dq_oe  = busy && (kind_q != K_READ);
        dq_out = byte_q;
        we_n   = !((state_q == ST_ACTIVE) && (kind_q != K_READ));
        re_n   = !((state_q == ST_ACTIVE) && (kind_q == K_READ));
    end

    // R2: phase counters stay inside the programmed length
    a_r2_setup_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SETUP) |-> (cnt_q <= setup_len));
    a_r2_active_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACTIVE) |-> (cnt_q <= width_len));
    // R7: a read result appears just after the read strobe was low
    a_r7_capture_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(!re_n));
    // R8: an accepted request makes the block busy
    a_r8_busy_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy) |=> busy);

endmodule

// File: rtl/nand_strobe_sequencer.sv
module nand_strobe_sequencer
    import nand_seq_pkg::*;
#(
    parameter bit  EXT_SETUP = 1'b0,
    parameter int  PHASE_W   = 3,
    parameter int  DQ_W      = 8,
    localparam int SETUP_W   = EXT_SETUP ? PHASE_W : PHASE_W - 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tim_load,
    input  logic [SETUP_W-1:0] tim_setup,
    input  logic [PHASE_W-1:0] tim_width,
    input  logic [PHASE_W-1:0] tim_hold,
    input  logic               req_valid,
    input  logic [1:0]         req_kind,
    input  logic [DQ_W-1:0]    req_byte,
    output logic               busy,
    input  logic               sel_chip,
    input  logic               rnb_in,
    output logic               ready,
    output logic               nce_n,
    output logic               cle,
    output logic               ale,
    output logic               we_n,
    output logic               re_n,
    output logic [DQ_W-1:0]    dq_out,
    output logic               dq_oe,
    input  logic [DQ_W-1:0]    dq_in,
    output logic [DQ_W-1:0]    rd_data,
    output logic               rd_valid
);
    logic [PHASE_W-1:0] setup_len, width_len, hold_len;

    nand_timing_bank #(.SETUP_W(SETUP_W), .PHASE_W(PHASE_W)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (tim_load),
        .idle      (!busy),
        .setup_in  (tim_setup),
        .width_in  (tim_width),
        .hold_in   (tim_hold),
        .setup_len (setup_len),
        .width_len (width_len),
        .hold_len  (hold_len)
    );

    nand_strobe_fsm #(.PHASE_W(PHASE_W), .DQ_W(DQ_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_kind  (req_kind),
        .req_byte  (req_byte),
        .setup_len (setup_len),
        .width_len (width_len),
        .hold_len  (hold_len),
        .dq_in     (dq_in),
        .busy      (busy),
        .cle       (cle),
        .ale       (ale),
        .we_n      (we_n),
        .re_n      (re_n),
        .dq_out    (dq_out),
        .dq_oe     (dq_oe),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid)
    );

    nand_rnb_sync u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (rnb_in),
        .sync_out (ready)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nce_n <= 1'b1;
        end else begin
            nce_n <= !sel_chip;
        end
    end

    // R12: strobes and latch enables are mutually exclusive
    a_r12_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(!we_n && !re_n));
    a_r12_one_latch: assert property (@(posedge clk) disable iff (!rst_n)
        !(cle && ale));
    // R11: chip enable drops only after a select request
    a_r11_select_first: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(nce_n) |-> $past(sel_chip));

endmodule

// File: tb/test_nand_strobe_sequencer.sv
module test_nand_strobe_sequencer;
    localparam int SMAX = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tim_load = 1'b0;
    logic [1:0] tim_setup = '0;
    logic [2:0] tim_width = '0, tim_hold = '0;
    logic       req_valid = 1'b0;
    logic [1:0] req_kind = '0;
    logic [7:0] req_byte = '0;
    logic       sel_chip = 1'b0, rnb_in = 1'b0;
    logic [7:0] dq_in = '0;
    logic       busy, ready, nce_n, cle, ale, we_n, re_n, dq_oe, rd_valid;
    logic [7:0] dq_out, rd_data;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    string cur_tag = "R3";

    always #4 clk = ~clk;

    nand_strobe_sequencer i_nand_strobe_sequencer (
        .clk(clk), .rst_n(rst_n), .tim_load(tim_load), .tim_setup(tim_setup),
        .tim_width(tim_width), .tim_hold(tim_hold), .req_valid(req_valid),
        .req_kind(req_kind), .req_byte(req_byte), .busy(busy), .sel_chip(sel_chip),
        .rnb_in(rnb_in), .ready(ready), .nce_n(nce_n), .cle(cle), .ale(ale),
        .we_n(we_n), .re_n(re_n), .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in),
        .rd_data(rd_data), .rd_valid(rd_valid)
    );

    // behavioural reference: a queue of phase codes (1 setup, 2 active, 3 hold)
    int         ph_q[$];
    int         m_s, m_w, m_h, m_kind;
    logic [7:0] m_byte, m_rdd;
    logic       m_rdv, m_s1, m_ready, m_nce;

    always @(posedge clk) begin
        if (!rst_n) begin
            ph_q.delete();
            m_s = SMAX - 1; m_w = 7; m_h = 7; m_kind = 0; m_byte = 0;
            m_rdd = 0; m_rdv = 0; m_s1 = 0; m_ready = 0; m_nce = 1;
        end else begin
            if (ph_q.size() > 0) begin
                m_rdv = 0;
                if (ph_q[0] == 2 && ph_q[1] == 3 && m_kind == 3) begin
                    m_rdd = dq_in;
                    m_rdv = 1;
                end
                void'(ph_q.pop_front());
            end else begin
                m_rdv = 0;
                if (req_valid) begin
                    m_kind = req_kind;
                    m_byte = req_byte;
                    for (int i = 0; i <= m_s; i++) ph_q.push_back(1);
                    for (int i = 0; i <= m_w; i++) ph_q.push_back(2);
                    for (int i = 0; i <= m_h; i++) ph_q.push_back(3);
                end
                if (tim_load) begin
                    m_s = tim_setup; m_w = tim_width; m_h = tim_hold;
                end
            end
            m_ready = m_s1;
            m_s1    = rnb_in;
            m_nce   = !sel_chip;
        end
    end

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        int p;
        if (rst_n) begin
            p = (ph_q.size() > 0) ? ph_q[0] : 0;
            chk("R8", "busy", busy, p != 0);
            chk("R4", "cle", cle, (p != 0) && m_kind == 0);
            chk("R5", "ale", ale, (p != 0) && m_kind == 1);
            chk(cur_tag, "we_n", we_n, !(p == 2 && m_kind != 3));
            chk("R7", "re_n", re_n, !(p == 2 && m_kind == 3));
            chk("R6", "dq_oe", dq_oe, (p != 0) && m_kind != 3);
            if (p != 0 && m_kind != 3) chk("R6", "dq_out", dq_out, m_byte);
            chk("R7", "rd_valid", rd_valid, m_rdv);
            chk("R7", "rd_data", rd_data, m_rdd);
            chk("R10", "ready", ready, m_ready);
            chk("R11", "nce_n", nce_n, m_nce);
            chk("R12", "strobe overlap", (!we_n && !re_n) || (cle && ale), 0);
        end
    end

    task automatic do_req(int kind, int b);
        req_valid = 1'b1; req_kind = kind[1:0]; req_byte = b[7:0];
        @(negedge clk);
        req_valid = 1'b0;
        while (busy) @(negedge clk);
    endtask

    task automatic load_tim(int s, int w, int h);
        tim_load = 1'b1; tim_setup = s[1:0]; tim_width = w[2:0]; tim_hold = h[2:0];
        @(negedge clk);
        tim_load = 1'b0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "nce_n", nce_n, 1); chk("R1", "busy", busy, 0);
        chk("R1", "we_n", we_n, 1);   chk("R1", "re_n", re_n, 1);
        chk("R1", "cle", cle, 0);     chk("R1", "ready", ready, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "dq_oe", dq_oe, 0); chk("R1", "rd_data", rd_data, 0);

        // R3: default maximum lengths
        cur_tag = "R3";
        do_req(0, 8'h70);
        do_req(3, 8'h00);

        // R2: programmed lengths, every kind
        cur_tag = "R2";
        load_tim(1, 2, 0);
        dq_in = 8'hA5;
        do_req(0, 8'h90);
        do_req(1, 8'h12);
        do_req(2, 8'h5A);
        do_req(3, 8'h00);
        load_tim(0, 0, 0);
        dq_in = 8'h3C;
        do_req(3, 8'h00);
        do_req(2, 8'hC3);
        do_req(1, 8'hFE);

        // R8, R9: request and timing load while busy are ignored
        cur_tag = "R9";
        load_tim(2, 3, 2);
        req_valid = 1'b1; req_kind = 2'd2; req_byte = 8'h81;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (2) @(negedge clk);
        req_valid = 1'b1; req_kind = 2'd0; req_byte = 8'hFF;
        load_tim(3, 7, 7);
        repeat (2) @(negedge clk);
        req_valid = 1'b0;
        while (busy) @(negedge clk);
        @(negedge clk);
        chk("R8", "no restart", busy, 0);
        do_req(0, 8'h60);
        load_tim(1, 1, 1);
        do_req(1, 8'h07);

        // R10, R11: synchronizer and chip enable
        rnb_in = 1'b1;
        @(negedge clk); chk("R10", "ready first edge", ready, 0);
        @(negedge clk); chk("R10", "ready second edge", ready, 1);
        sel_chip = 1'b1;
        @(negedge clk); chk("R11", "nce_n select", nce_n, 0);
        rnb_in = 1'b0;
        repeat (3) @(negedge clk);
        sel_chip = 1'b0;
        repeat (2) @(negedge clk);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule